// File: doc/BRIEF.md
# Multicycle Processor Main Controller

This block sequences a 32-bit load/store processor that spends several clock cycles on each instruction. From the 6-bit major opcode held in the instruction register and the overflow flag of the ALU, it steps a state machine. In every state it drives the select and enable lines of the shared datapath: memory read and write, address select, instruction latch, ALU operand selects, ALU operation class, next-PC source, PC write enables, branch polarity, register destination and write, write-back source, and the exception cause, cause-register and saved-PC enables.

The instruction set it sequences is load word, store word, register-register arithmetic, add immediate, branch-if-equal, branch-if-not-equal, jump and return-from-exception. An opcode it does not recognise traps to an exception state. An arithmetic overflow during register-register execution also traps, and the result is not written back. Both exception states save the current instruction's address (PC minus four) and a cause bit, then redirect the PC to the handler vector. Return-from-exception reloads the PC from the saved address. All outputs depend only on the current state. The state code is brought out so the integration can trace progress. A parameter selects whether the outputs come straight from a state decode or from a register loaded in the same cycle as the state. Both variants give the same cycle timing.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the controller into fetch (state code 0). Each of the completing states (codes 4, 5, 7, 8, 9, 10, 11, 12, 13, 14) is followed by fetch.
- R2: Any output not named for a state is 0 in that state. Fetch (code 0) asserts mem_rd, ir_wr and pc_wr, with iord=0, alu_src_a=0, alu_src_b=1, alu_op=0 and pc_src=0. It is always followed by decode.
- R3: Decode (code 1) drives alu_src_a=0, alu_src_b=3 and alu_op=0.
- R4: Opcodes 35 (load), 43 (store) and 8 (add immediate) go from decode to address compute (code 2). Address compute drives alu_src_a=1, alu_src_b=2 and alu_op=0.
- R5: A load continues to code 3 (mem_rd, iord=1), then to code 4 (reg_wr, reg_dst=0, mem_to_reg=1). mem_rd and mem_wr are never both high.
- R6: A store continues to code 5, which asserts mem_wr with iord=1.
- R7: Add immediate continues to code 10, which asserts reg_wr with reg_dst=0 and mem_to_reg=0.
- R8: Opcode 0 goes to execute (code 6: alu_src_a=1, alu_src_b=0, alu_op=2). With alu_ovf low in execute, it goes on to code 7 (reg_wr, reg_dst=1, mem_to_reg=0).
- R9: Opcode 4 goes to code 8 and opcode 5 goes to code 11. Both drive alu_src_a=1, alu_src_b=0, alu_op=1, pc_wr_cond=1 and pc_src=1. bne_sel is 0 in code 8 and 1 in code 11.
- R10: Opcode 2 goes to code 9, which asserts pc_wr with pc_src=2.
- R11: Any other opcode except 16 goes from decode to code 13. Code 13 drives alu_src_a=0, alu_src_b=1, alu_op=1, cause_wr, epc_wr, pc_wr, pc_src=3 and int_cause=0.
- R12: alu_ovf high in execute leads to code 12. Code 12 drives the same outputs as code 13 except int_cause=1. reg_wr stays low until the next fetch.
- R13: Opcode 16 goes from decode to code 14, which asserts pc_wr with pc_src=4 (saved PC).
- R14: alu_ovf has no effect in any state other than execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Major opcode from instruction register |
| alu_ovf | input | 1 | ALU arithmetic overflow flag |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| ir_wr | output | 1 | Instruction register load |
| alu_src_a | output | 1 | ALU A select: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B select: 0 reg B, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 function field |
| pc_src | output | 3 | PC source: 0 ALU, 1 ALU result reg, 2 jump, 3 vector, 4 saved PC |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | Conditional PC write |
| bne_sel | output | 1 | Branch polarity: 0 on equal, 1 on not equal |
| reg_dst | output | 1 | Destination field: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write |
| mem_to_reg | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| int_cause | output | 1 | Cause code: 0 undefined opcode, 1 overflow |
| cause_wr | output | 1 | Cause register load |
| epc_wr | output | 1 | Saved-PC register load |
| state_o | output | 4 | Current state code |

## Verification
Directed instructions of every opcode class walk each path and show that the state codes and control words differ where the paths diverge. That covers the shared address-compute state, which the next opcode steers three ways, and the two branch states that differ only in polarity. Overflow is driven high in execute and also on the load and add-immediate paths: this separates the trap from normal write-back and shows that overflow outside execute has no effect. Random instruction streams then mix the legal opcodes with random 6-bit values, some undefined, and apply overflow at random to the model's state sequence and control words. A reset asserted mid-instruction shows that reset takes precedence from any state.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam int STATE_W = 4;
   localparam int SRCB_W  = 2;
   localparam int ALUOP_W = 2;
   localparam int PCSRC_W = 3;

   typedef enum logic [STATE_W-1:0] {
      S_FETCH  = 4'd0,
      S_DECODE = 4'd1,
      S_ADDR   = 4'd2,
      S_LDMEM  = 4'd3,
      S_LDWB   = 4'd4,
      S_STMEM  = 4'd5,
      S_REXE   = 4'd6,
      S_RWB    = 4'd7,
      S_BEQ    = 4'd8,
      S_JMP    = 4'd9,
      S_IMMWB  = 4'd10,
      S_BNE    = 4'd11,
      S_OVF    = 4'd12,
      S_UNDEF  = 4'd13,
      S_RET    = 4'd14
   } state_e;

   typedef enum logic [3:0] {
      OC_RTYPE, OC_LOAD, OC_STORE, OC_ADDI,
      OC_BEQ, OC_BNE, OC_JUMP, OC_RET, OC_UNDEF
   } opclass_e;

   localparam logic [SRCB_W-1:0]  SB_REGB = 2'd0;
   localparam logic [SRCB_W-1:0]  SB_FOUR = 2'd1;
   localparam logic [SRCB_W-1:0]  SB_IMM  = 2'd2;
   localparam logic [SRCB_W-1:0]  SB_BOFF = 2'd3;

   localparam logic [ALUOP_W-1:0] AOP_ADD  = 2'd0;
   localparam logic [ALUOP_W-1:0] AOP_SUB  = 2'd1;
   localparam logic [ALUOP_W-1:0] AOP_FUNC = 2'd2;

   localparam logic [PCSRC_W-1:0] PCS_ALU  = 3'd0;
   localparam logic [PCSRC_W-1:0] PCS_OUT  = 3'd1;
   localparam logic [PCSRC_W-1:0] PCS_JUMP = 3'd2;
   localparam logic [PCSRC_W-1:0] PCS_VEC  = 3'd3;
   localparam logic [PCSRC_W-1:0] PCS_EPC  = 3'd4;

   typedef struct packed {
      logic               mem_rd;
      logic               mem_wr;
      logic               iord;
      logic               ir_wr;
      logic               src_a;
      logic [SRCB_W-1:0]  src_b;
      logic [ALUOP_W-1:0] alu_op;
      logic [PCSRC_W-1:0] pc_src;
      logic               pc_wr;
      logic               pc_wr_cond;
      logic               bne_sel;
      logic               reg_dst;
      logic               reg_wr;
      logic               mem_to_reg;
      logic               int_cause;
      logic               cause_wr;
      logic               epc_wr;
   } ctrl_t;

endpackage

// File: rtl/mcc_opdec.sv
module mcc_opdec
   import mcc_pkg::*;
#(
   parameter int          OPC_W    = 6,
   parameter int unsigned OP_RTYPE = 0,
   parameter int unsigned OP_LOAD  = 35,
   parameter int unsigned OP_STORE = 43,
   parameter int unsigned OP_ADDI  = 8,
   parameter int unsigned OP_BEQ   = 4,
   parameter int unsigned OP_BNE   = 5,
   parameter int unsigned OP_JUMP  = 2,
   parameter int unsigned OP_RET   = 16
)(
   input  logic [OPC_W-1:0] opcode,
   output opclass_e         cls
);

   localparam int NUM_OPS = 8;
   localparam int unsigned OP_LIMIT = 1 << OPC_W;
   localparam int unsigned OPS [NUM_OPS] = '{OP_RTYPE, OP_LOAD, OP_STORE,
      OP_ADDI, OP_BEQ, OP_BNE, OP_JUMP, OP_RET};

   initial begin
      assert (OPC_W >= 3 && OPC_W <= 16)
         else $error("mcc_opdec: OPC_W out of range");
      for (int i = 0; i < NUM_OPS; i++) begin
         assert (OPS[i] < OP_LIMIT)
            else $error("mcc_opdec: opcode %0d does not fit", i);
         for (int j = i + 1; j < NUM_OPS; j++)
            assert (OPS[i] != OPS[j])
               else $error("mcc_opdec: opcodes %0d and %0d collide", i, j);
      end
   end

   always_comb begin
      if      (opcode == OPC_W'(OP_RTYPE)) cls = OC_RTYPE;
      else if (opcode == OPC_W'(OP_LOAD))  cls = OC_LOAD;
      else if (opcode == OPC_W'(OP_STORE)) cls = OC_STORE;
      else if (opcode == OPC_W'(OP_ADDI))  cls = OC_ADDI;
      else if (opcode == OPC_W'(OP_BEQ))   cls = OC_BEQ;
      else if (opcode == OPC_W'(OP_BNE))   cls = OC_BNE;
      else if (opcode == OPC_W'(OP_JUMP))  cls = OC_JUMP;
      else if (opcode == OPC_W'(OP_RET))   cls = OC_RET;
      else                                 cls = OC_UNDEF;
   end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
   import mcc_pkg::*;
(
   input  state_e   cur,
   input  opclass_e cls,
   input  logic     alu_ovf,
   output state_e   nxt
);

   always_comb begin
      nxt = S_FETCH;
      unique case (cur)
         S_FETCH:  nxt = S_DECODE;
         S_DECODE: begin
            unique case (cls)
               OC_RTYPE: nxt = S_REXE;
               OC_LOAD,
               OC_STORE,
               OC_ADDI:  nxt = S_ADDR;
               OC_BEQ:   nxt = S_BEQ;
               OC_BNE:   nxt = S_BNE;
               OC_JUMP:  nxt = S_JMP;
               OC_RET:   nxt = S_RET;
               default:  nxt = S_UNDEF;
            endcase
         end
         S_ADDR: begin
            if      (cls == OC_LOAD)  nxt = S_LDMEM;
            else if (cls == OC_STORE) nxt = S_STMEM;
            else if (cls == OC_ADDI)  nxt = S_IMMWB;
            else                      nxt = S_FETCH;
         end
         S_LDMEM:  nxt = S_LDWB;
         // overflow is only meaningful while the register-register result is on the ALU
         S_REXE:   nxt = alu_ovf ? S_OVF : S_RWB;
         default:  nxt = S_FETCH;
      endcase
   end

endmodule

// File: rtl/mcc_ctrl_rom.sv
module mcc_ctrl_rom
   import mcc_pkg::*;
(
   input  state_e st,
   output ctrl_t  c
);

   always_comb begin
      c = '0;
      unique case (st)
         S_FETCH: begin
            c.mem_rd = 1'b1;
            c.ir_wr  = 1'b1;
            c.pc_wr  = 1'b1;
            c.src_b  = SB_FOUR;
            c.alu_op = AOP_ADD;
            c.pc_src = PCS_ALU;
         end
         S_DECODE: begin
            c.src_b  = SB_BOFF;
            c.alu_op = AOP_ADD;
         end
         S_ADDR: begin
            c.src_a  = 1'b1;
            c.src_b  = SB_IMM;
            c.alu_op = AOP_ADD;
         end
         S_LDMEM: begin
            c.mem_rd = 1'b1;
            c.iord   = 1'b1;
         end
         S_LDWB: begin
            c.reg_wr     = 1'b1;
            c.mem_to_reg = 1'b1;
         end
         S_STMEM: begin
            c.mem_wr = 1'b1;
            c.iord   = 1'b1;
         end
         S_REXE: begin
            c.src_a  = 1'b1;
            c.src_b  = SB_REGB;
            c.alu_op = AOP_FUNC;
         end
         S_RWB: begin
            c.reg_wr  = 1'b1;
            c.reg_dst = 1'b1;
         end
         S_BEQ, S_BNE: begin
            c.src_a      = 1'b1;
            c.src_b      = SB_REGB;
            c.alu_op     = AOP_SUB;
            c.pc_wr_cond = 1'b1;
            c.pc_src     = PCS_OUT;
            c.bne_sel    = (st == S_BNE);
         end
         S_JMP: begin
            c.pc_wr  = 1'b1;
            c.pc_src = PCS_JUMP;
         end
         S_IMMWB: begin
            c.reg_wr = 1'b1;
         end
         S_OVF, S_UNDEF: begin
            // ALU forms PC-4 so the saved address points at the faulting instruction
            c.src_b     = SB_FOUR;
            c.alu_op    = AOP_SUB;
            c.cause_wr  = 1'b1;
            c.epc_wr    = 1'b1;
            c.pc_wr     = 1'b1;
            c.pc_src    = PCS_VEC;
            c.int_cause = (st == S_OVF);
         end
         S_RET: begin
            c.pc_wr  = 1'b1;
            c.pc_src = PCS_EPC;
         end
         default: c = '0;
      endcase
   end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
   import mcc_pkg::*;
#(
   parameter int          OPC_W    = 6,
   parameter int unsigned OP_RTYPE = 0,
   parameter int unsigned OP_LOAD  = 35,
   parameter int unsigned OP_STORE = 43,
   parameter int unsigned OP_ADDI  = 8,
   parameter int unsigned OP_BEQ   = 4,
   parameter int unsigned OP_BNE   = 5,
   parameter int unsigned OP_JUMP  = 2,
   parameter int unsigned OP_RET   = 16,
   parameter bit          OUT_REG  = 1'b0
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [OPC_W-1:0]   opcode,
   input  logic               alu_ovf,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic               iord,
   output logic               ir_wr,
   output logic               alu_src_a,
   output logic [SRCB_W-1:0]  alu_src_b,
   output logic [ALUOP_W-1:0] alu_op,
   output logic [PCSRC_W-1:0] pc_src,
   output logic               pc_wr,
   output logic               pc_wr_cond,
   output logic               bne_sel,
   output logic               reg_dst,
   output logic               reg_wr,
   output logic               mem_to_reg,
   output logic               int_cause,
   output logic               cause_wr,
   output logic               epc_wr,
   output logic [STATE_W-1:0] state_o
);

   state_e   state_q, state_d, state_nxt;
   opclass_e cls;
   ctrl_t    ctl;

   mcc_opdec #(
      .OPC_W(OPC_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
      .OP_STORE(OP_STORE), .OP_ADDI(OP_ADDI), .OP_BEQ(OP_BEQ),
      .OP_BNE(OP_BNE), .OP_JUMP(OP_JUMP), .OP_RET(OP_RET)
   ) u_opdec (
      .opcode (opcode),
      .cls    (cls)
   );

   mcc_next_state u_next (
      .cur     (state_q),
      .cls     (cls),
      .alu_ovf (alu_ovf),
      .nxt     (state_nxt)
   );

   assign state_d = rst ? S_FETCH : state_nxt;

   always_ff @(posedge clk) begin
      state_q <= state_d;
   end

   generate
      if (OUT_REG) begin : g_out_reg
         ctrl_t ctl_d;
         mcc_ctrl_rom u_rom (.st(state_d), .c(ctl_d));
         always_ff @(posedge clk) begin
            ctl <= ctl_d;
         end
      end else begin : g_out_comb
         mcc_ctrl_rom u_rom (.st(state_q), .c(ctl));
      end
   endgenerate

   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign iord       = ctl.iord;
   assign ir_wr      = ctl.ir_wr;
   assign alu_src_a  = ctl.src_a;
   assign alu_src_b  = ctl.src_b;
   assign alu_op     = ctl.alu_op;
   assign pc_src     = ctl.pc_src;
   assign pc_wr      = ctl.pc_wr;
   assign pc_wr_cond = ctl.pc_wr_cond;
   assign bne_sel    = ctl.bne_sel;
   assign reg_dst    = ctl.reg_dst;
   assign reg_wr     = ctl.reg_wr;
   assign mem_to_reg = ctl.mem_to_reg;
   assign int_cause  = ctl.int_cause;
   assign cause_wr   = ctl.cause_wr;
   assign epc_wr     = ctl.epc_wr;
   assign state_o    = state_q;

   // R1: reset wins from any state
   p_rst_fetch_r1: assert property (@(posedge clk)
      rst |=> state_q == S_FETCH);

   // R1: completing states hand back to fetch
   p_done_fetch_r1: assert property (@(posedge clk) disable iff (rst)
      (state_q inside {S_LDWB, S_STMEM, S_RWB, S_BEQ, S_JMP, S_IMMWB,
                       S_BNE, S_OVF, S_UNDEF, S_RET}) |=> state_q == S_FETCH);

   p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
      state_q == S_FETCH |=> state_q == S_DECODE);

   p_mem_excl_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mem_rd, mem_wr}));

   p_no_ovf_r8: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_REXE && !alu_ovf) |=> state_q == S_RWB);

   p_bad_op_r11: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_DECODE && cls == OC_UNDEF) |=> (state_q == S_UNDEF && !int_cause));

   p_exc_save_r11: assert property (@(posedge clk) disable iff (rst)
      cause_wr |-> (epc_wr && pc_wr && pc_src == PCS_VEC && !reg_wr));

   p_ovf_trap_r12: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_REXE && alu_ovf) |=> (state_q == S_OVF && int_cause && !reg_wr));

   p_ret_epc_r13: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_DECODE && cls == OC_RET) |=> (pc_wr && pc_src == PCS_EPC));

   p_ovf_ignored_r14: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_ADDR && cls == OC_ADDI) |=> state_q == S_IMMWB);

endmodule

// File: tb/test_mcc_ctrl.sv
module test_mcc_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int RAND_STEPS = 4000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = '0;
   logic       alu_ovf = 1'b0;
   logic       mem_rd, mem_wr, iord, ir_wr, alu_src_a;
   logic [1:0] alu_src_b, alu_op;
   logic [2:0] pc_src;
   logic       pc_wr, pc_wr_cond, bne_sel, reg_dst, reg_wr, mem_to_reg;
   logic       int_cause, cause_wr, epc_wr;
   logic [3:0] state_o;

   int checks = 0;
   int errors = 0;
   int model  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcc_ctrl i_mcc_ctrl (
      .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .iord(iord), .ir_wr(ir_wr),
      .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
      .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
      .bne_sel(bne_sel), .reg_dst(reg_dst), .reg_wr(reg_wr),
      .mem_to_reg(mem_to_reg), .int_cause(int_cause), .cause_wr(cause_wr),
      .epc_wr(epc_wr), .state_o(state_o)
   );

   // opcode classes: 0 rtype 1 load 2 store 3 addi 4 beq 5 bne 6 jump 7 ret 8 undefined
   function automatic int classify(logic [5:0] op);
      case (op)
         6'd0:  return 0;
         6'd35: return 1;
         6'd43: return 2;
         6'd8:  return 3;
         6'd4:  return 4;
         6'd5:  return 5;
         6'd2:  return 6;
         6'd16: return 7;
         default: return 8;
      endcase
   endfunction

   function automatic int next_of(int s, logic [5:0] op, logic ovf);
      int c = classify(op);
      case (s)
         0: return 1;
         1: case (c)
               0: return 6;
               1, 2, 3: return 2;
               4: return 8;
               5: return 11;
               6: return 9;
               7: return 14;
               default: return 13;
            endcase
         2: return (c == 1) ? 3 : (c == 2) ? 5 : (c == 3) ? 10 : 0;
         3: return 4;
         6: return ovf ? 12 : 7;
         default: return 0;
      endcase
   endfunction

   function automatic logic [20:0] exp_ctrl(int s);
      logic mr = 0, mw = 0, io = 0, irw = 0, sa = 0;
      logic [1:0] sb = 0, ao = 0;
      logic [2:0] ps = 0;
      logic pw = 0, pwc = 0, bn = 0, rd = 0, rw = 0, m2r = 0, ic = 0, cw = 0, ew = 0;
      case (s)
         0: begin mr = 1; irw = 1; pw = 1; sb = 1; end
         1: sb = 3;
         2: begin sa = 1; sb = 2; end
         3: begin mr = 1; io = 1; end
         4: begin rw = 1; m2r = 1; end
         5: begin mw = 1; io = 1; end
         6: begin sa = 1; ao = 2; end
         7: begin rw = 1; rd = 1; end
         8, 11: begin sa = 1; ao = 1; pwc = 1; ps = 1; bn = (s == 11); end
         9: begin pw = 1; ps = 2; end
         10: rw = 1;
         12, 13: begin sb = 1; ao = 1; cw = 1; ew = 1; pw = 1; ps = 3; ic = (s == 12); end
         14: begin pw = 1; ps = 4; end
         default: ;
      endcase
      return {mr, mw, io, irw, sa, sb, ao, ps, pw, pwc, bn, rd, rw, m2r, ic, cw, ew};
   endfunction

   function automatic string req_of(int s);
      case (s)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3, 4: return "R5";
         5: return "R6";
         6, 7: return "R8";
         8, 11: return "R9";
         9: return "R10";
         10: return "R7";
         12: return "R12";
         13: return "R11";
         14: return "R13";
         default: return "R1";
      endcase
   endfunction

   function automatic logic [20:0] act_ctrl();
      return {mem_rd, mem_wr, iord, ir_wr, alu_src_a, alu_src_b, alu_op, pc_src,
              pc_wr, pc_wr_cond, bne_sel, reg_dst, reg_wr, mem_to_reg,
              int_cause, cause_wr, epc_wr};
   endfunction

   task automatic check_now(string tag);
      string t = (tag == "") ? req_of(model) : tag;
      checks++;
      if (state_o !== 4'(model)) begin
         errors++;
         $display("FAIL %s state act=%0d exp=%0d", t, state_o, model);
      end
      checks++;
      if (act_ctrl() !== exp_ctrl(model)) begin
         errors++;
         $display("FAIL %s ctrl in state %0d act=%h exp=%h", t, model, act_ctrl(), exp_ctrl(model));
      end
   endtask

   // called at a falling edge: check, drive the next inputs, advance the model
   task automatic step(logic [5:0] op, logic ovf, logic r, string tag);
      check_now(tag);
      opcode  = op;
      alu_ovf = ovf;
      rst     = r;
      model   = r ? 0 : next_of(model, op, ovf);
      @(negedge clk);
   endtask

   // run one instruction from fetch back to fetch with fixed overflow level
   task automatic run_instr(logic [5:0] op, logic ovf, string tag);
      step(op, ovf, 1'b0, tag);
      while (model != 0) step(op, ovf, 1'b0, tag);
   endtask

   initial begin
      int dummy;
      dummy = $urandom(32'h5EED_C0DE);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      model = 0;
      check_now("R1");
      rst = 1'b0;

      run_instr(6'd35, 1'b0, "");    // R5 load
      run_instr(6'd43, 1'b0, "");    // R6 store
      run_instr(6'd8,  1'b0, "");    // R7 addi
      run_instr(6'd0,  1'b0, "");    // R8 rtype
      run_instr(6'd4,  1'b0, "");    // R9 beq
      run_instr(6'd5,  1'b0, "");    // R9 bne
      run_instr(6'd2,  1'b0, "");    // R10 jump
      run_instr(6'd63, 1'b0, "R11");
      run_instr(6'd0,  1'b1, "R12");
      run_instr(6'd16, 1'b0, "R13");
      // R14: overflow held high on paths that must ignore it
      run_instr(6'd8,  1'b1, "R14");
      run_instr(6'd35, 1'b1, "R14");
      run_instr(6'd4,  1'b1, "R14");
      // R1: reset asserted mid-instruction (in execute)
      step(6'd0, 1'b0, 1'b0, "R1");
      step(6'd0, 1'b0, 1'b0, "R1");
      step(6'd0, 1'b1, 1'b1, "R1");
      step(6'd0, 1'b0, 1'b0, "R1");

      begin
         logic [5:0] op = 6'd0;
         for (int i = 0; i < RAND_STEPS; i++) begin
            if (model == 0) begin
               case ($urandom % 10)
                  0: op = 6'd0;
                  1: op = 6'd35;
                  2: op = 6'd43;
                  3: op = 6'd8;
                  4: op = 6'd4;
                  5: op = 6'd5;
                  6: op = 6'd2;
                  7: op = 6'd16;
                  default: op = 6'($urandom);
               endcase
            end
            step(op, 1'($urandom), ($urandom % 200) == 0, "");
         end
      end
      check_now("");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule